// File: doc/BRIEF.md
# Low-Power DRAM Deep Sleep and Clock-Change Sequencer

This block sits on the controller side of a mobile low-power DRAM channel. It takes host requests to put the memory into deep power-down, to wake it, and to stop or retune the memory clock. It drives the clock-enable and chip-select lines and a two-bit command code. It opens a permission window for the clock generator only when doing so is safe.

A clock change is granted only after the last activate and precharge have run their delays. No bank operation may be pending, and refresh must be up to date. The clock-enable line must also have been low for two cycles. After the host reports the new clock, the block waits for two cycles of a stable clock before raising clock-enable. It then sets a flag asking the host to rewrite latency-related mode registers.

Deep power-down entry waits for the precharge delay. It issues a single entry command and holds the memory asleep for at least a programmed minimum time. Wake-up does not return straight to normal operation. The block raises clock-enable on a stable clock and waits out the clock-enable setup time. It then holds a reinitialization request to an external init engine until that engine reports completion.

Timing values are cycle counts that can be reprogrammed at run time. A request whose conditions are not yet met waits and is not lost.

Top module: `lp_mem_pwr_seq`

## Requirements
- R1: After synchronous active-low reset: `cke`=1, `cs_n`=1, `cmd`=2'b00, and `clk_chg_ok`, `reinit_req`, `mrw_flag` and `busy` are all 0.
- R2: A clock-change request drops `cke` only on an edge where all of these hold: `bank_busy`=0, `ref_ok`=1, and both the row-to-column and precharge timers have expired. Until then the request stays pending.
- R3: `clk_chg_ok` is 1 only while `cke`=0, and it rises only after `cke` has been low for two full cycles.
- R4: `req_clk_done` closes the window (`clk_chg_ok`=0). After that, `cke` stays low until `clk_stable` has been sampled high on two consecutive edges, and `cke` rises on the second of them.
- R5: `mrw_flag` is set in the same cycle that `cke` returns high after a clock change. It stays set until `mrw_ack` is sampled high.
- R6: Deep power-down entry waits for `bank_busy`=0 and for the precharge timer to expire. The entry cycle drives `cmd`=2'b10 with `cs_n`=0 for exactly one cycle, and `cke` goes low in that same cycle.
- R7: On every cycle other than the entry cycle, `cmd`=2'b00 (no operation) and `cs_n`=1.
- R8: `cke` stays low for at least the programmed minimum deep power-down count after the entry cycle. A wake request made earlier waits for that count.
- R9: Wake raises `cke` only when `clk_stable`=1. `reinit_req` rises once the clock-enable setup count has run out after `cke` rises, and it stays high until `init_done`. Only then does the block return to idle. A wake request while idle has no effect.
- R10: When deep power-down and clock-change requests are both ready, deep power-down goes first. The clock change stays pending and is served after reinitialization.
- R11: The four timer counts are written with `cfg_we`, selected by `cfg_sel`: 0 for row-to-column, 1 for precharge, 2 for minimum deep power-down, 3 for clock-enable setup. A timer loaded with N at an edge expires N edges later. `act_issued` loads the row-to-column timer and `pre_issued` loads the precharge timer.
- R12: `busy` is 1 exactly when the sequencer is not idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_dpd_enter | input | 1 | Pulse: request deep power-down |
| req_dpd_exit | input | 1 | Pulse: request wake from deep power-down |
| req_clk_chg | input | 1 | Pulse: request clock stop or frequency change |
| req_clk_done | input | 1 | Host reports that the new clock is in place |
| bank_busy | input | 1 | An activate or precharge is still in progress |
| ref_ok | input | 1 | Refresh is up to date and only refresh may be in flight |
| act_issued | input | 1 | Pulse: an activate was issued (starts row-to-column timer) |
| pre_issued | input | 1 | Pulse: a precharge was issued (starts precharge timer) |
| clk_stable | input | 1 | Memory clock meets its absolute high and low widths |
| init_done | input | 1 | External init engine has finished |
| mrw_ack | input | 1 | Host has rewritten the latency mode registers |
| cfg_we | input | 1 | Timer count write enable |
| cfg_sel | input | 2 | Timer count select |
| cfg_wdata | input | TW | Timer count value in cycles |
| cke | output | 1 | Memory clock enable |
| cs_n | output | 1 | Memory chip select, active low |
| cmd | output | 2 | Command code: 2'b00 no operation, 2'b10 deep power-down entry |
| clk_chg_ok | output | 1 | Clock may be stopped or retuned |
| reinit_req | output | 1 | Request for full power-up reinitialization |
| mrw_flag | output | 1 | Latency mode registers need rewriting |
| busy | output | 1 | Sequencer is not idle |

## Verification
The embedded properties check on every cycle that the permission window only opens during clock-enable low. They also check the two-cycle guards on both sides of the window, the single-cycle entry command with chip select and clock-enable low, and the precondition checks before leaving idle. A further property checks that wake always leads into reinitialization rather than idle. The bench scenarios are what show exact timer latencies for programmed counts, the holding of requests that arrive too early, and the ordering when both requests compete. They also show the flag handshake with the host and the lack of effect of a stray wake request.

// File: rtl/lpseq_pkg.sv
// Shared types for the low-power sequencer.
// Assumes: timer indices match the cfg_sel encoding.
package lpseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_DPD_CMD   = 3'd1,
        ST_DPD_HOLD  = 3'd2,
        ST_DPD_WAKE  = 3'd3,
        ST_REINIT    = 3'd4,
        ST_CKE_LOW   = 3'd5,
        ST_CLK_FREE  = 3'd6,
        ST_CKE_PREP  = 3'd7
    } seq_state_t;

    typedef enum logic [1:0] {
        CMD_NOP = 2'b00,
        CMD_DPD = 2'b10
    } bus_cmd_t;

    localparam int NUM_TMR = 4;
    localparam int TMR_RCD = 0;
    localparam int TMR_RP  = 1;
    localparam int TMR_DPD = 2;
    localparam int TMR_CKE = 3;

endpackage

// File: rtl/lpseq_cfg.sv
// Holds the loadable timer counts, one register per timer.
// Assumes: cfg_sel encodes the timer index from lpseq_pkg.
module lpseq_cfg
    import lpseq_pkg::*;
#(
    parameter int TW = 8,
    parameter logic [NUM_TMR*TW-1:0] RST_VALS = '0
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           we,
    input  logic [$clog2(NUM_TMR)-1:0]     sel,
    input  logic [TW-1:0]                  wdata,
    output logic [NUM_TMR-1:0][TW-1:0]     vals
);
    localparam int SW = $clog2(NUM_TMR);

    for (genvar gi = 0; gi < NUM_TMR; gi++) begin : g_reg
        // Capture a new count for this timer when selected.
        always_ff @(posedge clk) begin
            if (!rst_n)
                vals[gi] <= RST_VALS[gi*TW +: TW];
            else if (we && sel == SW'(gi))
                vals[gi] <= wdata;
        end
    end

endmodule

// File: rtl/lpseq_timer.sv
// Loadable down-counter; expired is high when the count is zero.
// Assumes: a load of N at an edge gives expired N edges later.
module lpseq_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] value,
    output logic          expired
);
    logic [TW-1:0] cnt;

    // Load on request, otherwise count down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= value;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    // Report expiry.
    always_comb expired = (cnt == '0);

    AST_EXPIRED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !load) |=> expired); // R11
    AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (expired == ($past(value) == '0))); // R11

endmodule

// File: rtl/lpseq_fsm.sv
// Sequencer state machine: deep power-down entry/exit and clock-change
// window. Holds pending requests and produces Moore outputs only.
// Assumes: timer expiry inputs come from lpseq_timer instances.
module lpseq_fsm
    import lpseq_pkg::*;
#(
    parameter int GUARD = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_dpd_enter,
    input  logic       req_dpd_exit,
    input  logic       req_clk_chg,
    input  logic       req_clk_done,
    input  logic       bank_busy,
    input  logic       ref_ok,
    input  logic       clk_stable,
    input  logic       init_done,
    input  logic       mrw_ack,
    input  logic       rcd_exp,
    input  logic       rp_exp,
    input  logic       dpd_exp,
    input  logic       cke_exp,
    output logic       dpd_load,
    output logic       cke_load,
    output logic       cke,
    output logic       cs_n,
    output logic [1:0] cmd,
    output logic       clk_chg_ok,
    output logic       reinit_req,
    output logic       mrw_flag,
    output logic       busy
);
    localparam int GW = $clog2(GUARD + 1);
    localparam logic [GW-1:0] GLAST = GW'(GUARD - 1);

    seq_state_t    st, nxt;
    logic          dpd_pend, chg_pend, exit_pend;
    logic [GW-1:0] guard_cnt;
    logic          chg_ready, dpd_ready;

    // Preconditions for leaving idle.
    always_comb begin
        dpd_ready = dpd_pend && rp_exp && !bank_busy;
        chg_ready = chg_pend && rcd_exp && rp_exp && !bank_busy && ref_ok;
    end

    // Next-state selection and timer load strobes.
    always_comb begin
        nxt      = st;
        dpd_load = 1'b0;
        cke_load = 1'b0;
        case (st)
            ST_IDLE: begin
                if (dpd_ready) begin
                    nxt      = ST_DPD_CMD;
                    dpd_load = 1'b1;
                end else if (chg_ready) begin
                    nxt = ST_CKE_LOW;
                end
            end
            ST_DPD_CMD:  nxt = ST_DPD_HOLD;
            ST_DPD_HOLD: begin
                if (exit_pend && dpd_exp && clk_stable) begin
                    nxt      = ST_DPD_WAKE;
                    cke_load = 1'b1;
                end
            end
            ST_DPD_WAKE: if (cke_exp)              nxt = ST_REINIT;
            ST_REINIT:   if (init_done)            nxt = ST_IDLE;
            ST_CKE_LOW:  if (guard_cnt == GLAST)   nxt = ST_CLK_FREE;
            ST_CLK_FREE: if (req_clk_done)         nxt = ST_CKE_PREP;
            ST_CKE_PREP: if (clk_stable && guard_cnt == GLAST) nxt = ST_IDLE;
            default:     nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    // Guard counter: cycles of CKE low, or consecutive stable clock cycles.
    always_ff @(posedge clk) begin
        if (!rst_n || nxt != st)
            guard_cnt <= '0;
        else if (st == ST_CKE_LOW && guard_cnt != GLAST)
            guard_cnt <= guard_cnt + 1'b1;
        else if (st == ST_CKE_PREP)
            guard_cnt <= clk_stable ? guard_cnt + 1'b1 : '0;
    end

    // Deep power-down request stays pending until entry.
    always_ff @(posedge clk) begin
        if (!rst_n)                            dpd_pend <= 1'b0;
        else if (st == ST_IDLE && dpd_ready)   dpd_pend <= 1'b0;
        else if (req_dpd_enter)                dpd_pend <= 1'b1;
    end

    // Clock-change request stays pending until CKE drops for it.
    always_ff @(posedge clk) begin
        if (!rst_n)                                         chg_pend <= 1'b0;
        else if (st == ST_IDLE && !dpd_ready && chg_ready)  chg_pend <= 1'b0;
        else if (req_clk_chg)                               chg_pend <= 1'b1;
    end

    // Wake request is only accepted while asleep; held until wake starts.
    always_ff @(posedge clk) begin
        if (!rst_n)                 exit_pend <= 1'b0;
        else if (nxt == ST_DPD_WAKE) exit_pend <= 1'b0;
        else if (req_dpd_exit && (st == ST_DPD_CMD || st == ST_DPD_HOLD))
            exit_pend <= 1'b1;
    end

    // Mode-register rewrite flag after a clock change completes.
    always_ff @(posedge clk) begin
        if (!rst_n)                                 mrw_flag <= 1'b0;
        else if (st == ST_CKE_PREP && nxt == ST_IDLE) mrw_flag <= 1'b1;
        else if (mrw_ack)                           mrw_flag <= 1'b0;
    end

    // Moore outputs decoded from the state.
    always_comb begin
        cke        = !(st inside {ST_DPD_CMD, ST_DPD_HOLD, ST_CKE_LOW,
                                  ST_CLK_FREE, ST_CKE_PREP});
        cs_n       = (st != ST_DPD_CMD);
        cmd        = (st == ST_DPD_CMD) ? CMD_DPD : CMD_NOP;
        clk_chg_ok = (st == ST_CLK_FREE);
        reinit_req = (st == ST_REINIT);
        busy       = (st != ST_IDLE);
    end

    AST_CHG_OK_CKE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        clk_chg_ok |-> !cke); // R3
    AST_CKE_LOW_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_chg_ok) |-> (!$past(cke) && !$past(cke, 2))); // R3
    AST_CKE_RISE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && $past(st) == ST_CKE_PREP) |-> ($past(clk_stable) && $past(clk_stable, 2))); // R4
    AST_CHG_PRECOND: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_CKE_LOW && $past(st) == ST_IDLE) |-> $past(rcd_exp && rp_exp && ref_ok && !bank_busy)); // R2
    AST_DPD_PRECOND: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DPD_CMD) |-> $past(rp_exp && !bank_busy)); // R6
    AST_DPD_CMD_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_DPD) |-> (!cs_n && !cke)); // R6
    AST_DPD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_DPD) |=> (cmd == CMD_NOP)); // R6
    AST_CS_ONLY_DPD: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> (cmd == CMD_DPD)); // R7
    AST_WAKE_TO_REINIT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st) == ST_DPD_WAKE && st != ST_DPD_WAKE) |-> (st == ST_REINIT)); // R9
    AST_WAKE_NEEDS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DPD_WAKE && $past(st) == ST_DPD_HOLD) |-> $past(clk_stable && dpd_exp)); // R8
    AST_IDLE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && $past(st) != ST_IDLE) |-> ($past(st) == ST_REINIT || $past(st) == ST_CKE_PREP)); // R9

endmodule

// File: rtl/lp_mem_pwr_seq.sv
// Top of the low-power sequencer: timer count registers, four
// down-counters and the state machine.
// Assumes: act_issued / pre_issued are single-cycle pulses from the
// command scheduler.
module lp_mem_pwr_seq
    import lpseq_pkg::*;
#(
    parameter int TW        = 8,
    parameter int GUARD     = 2,
    parameter int RST_RCD   = 2,
    parameter int RST_RP    = 2,
    parameter int RST_DPD   = 8,
    parameter int RST_CKE   = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_dpd_enter,
    input  logic          req_dpd_exit,
    input  logic          req_clk_chg,
    input  logic          req_clk_done,
    input  logic          bank_busy,
    input  logic          ref_ok,
    input  logic          act_issued,
    input  logic          pre_issued,
    input  logic          clk_stable,
    input  logic          init_done,
    input  logic          mrw_ack,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [TW-1:0] cfg_wdata,
    output logic          cke,
    output logic          cs_n,
    output logic [1:0]    cmd,
    output logic          clk_chg_ok,
    output logic          reinit_req,
    output logic          mrw_flag,
    output logic          busy
);
    localparam logic [NUM_TMR*TW-1:0] RST_VALS =
        {TW'(RST_CKE), TW'(RST_DPD), TW'(RST_RP), TW'(RST_RCD)};

    logic [NUM_TMR-1:0][TW-1:0] tmr_val;
    logic [NUM_TMR-1:0]         tmr_load;
    logic [NUM_TMR-1:0]         tmr_exp;
    logic                       dpd_load, cke_load;

    lpseq_cfg #(.TW(TW), .RST_VALS(RST_VALS)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .sel   (cfg_sel),
        .wdata (cfg_wdata),
        .vals  (tmr_val)
    );

    // Route load strobes to their timers.
    always_comb begin
        tmr_load          = '0;
        tmr_load[TMR_RCD] = act_issued;
        tmr_load[TMR_RP]  = pre_issued;
        tmr_load[TMR_DPD] = dpd_load;
        tmr_load[TMR_CKE] = cke_load;
    end

    for (genvar gt = 0; gt < NUM_TMR; gt++) begin : g_tmr
        lpseq_timer #(.TW(TW)) u_tmr (
            .clk     (clk),
            .rst_n   (rst_n),
            .load    (tmr_load[gt]),
            .value   (tmr_val[gt]),
            .expired (tmr_exp[gt])
        );
    end

    lpseq_fsm #(.GUARD(GUARD)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_dpd_enter (req_dpd_enter),
        .req_dpd_exit  (req_dpd_exit),
        .req_clk_chg   (req_clk_chg),
        .req_clk_done  (req_clk_done),
        .bank_busy     (bank_busy),
        .ref_ok        (ref_ok),
        .clk_stable    (clk_stable),
        .init_done     (init_done),
        .mrw_ack       (mrw_ack),
        .rcd_exp       (tmr_exp[TMR_RCD]),
        .rp_exp        (tmr_exp[TMR_RP]),
        .dpd_exp       (tmr_exp[TMR_DPD]),
        .cke_exp       (tmr_exp[TMR_CKE]),
        .dpd_load      (dpd_load),
        .cke_load      (cke_load),
        .cke           (cke),
        .cs_n          (cs_n),
        .cmd           (cmd),
        .clk_chg_ok    (clk_chg_ok),
        .reinit_req    (reinit_req),
        .mrw_flag      (mrw_flag),
        .busy          (busy)
    );

endmodule

// File: tb/sim_lp_mem_pwr_seq.sv
`timescale 1ns/1ps
module sim_lp_mem_pwr_seq;
    localparam int TW = 8;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n, req_dpd_enter, req_dpd_exit, req_clk_chg, req_clk_done;
    logic bank_busy, ref_ok, act_issued, pre_issued, clk_stable, init_done, mrw_ack;
    logic cfg_we;
    logic [1:0] cfg_sel;
    logic [TW-1:0] cfg_wdata;
    logic cke, cs_n, clk_chg_ok, reinit_req, mrw_flag, busy;
    logic [1:0] cmd;

    lp_mem_pwr_seq #(.TW(TW)) u0 (
        .clk(clk), .rst_n(rst_n), .req_dpd_enter(req_dpd_enter), .req_dpd_exit(req_dpd_exit),
        .req_clk_chg(req_clk_chg), .req_clk_done(req_clk_done), .bank_busy(bank_busy),
        .ref_ok(ref_ok), .act_issued(act_issued), .pre_issued(pre_issued),
        .clk_stable(clk_stable), .init_done(init_done), .mrw_ack(mrw_ack),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .cke(cke), .cs_n(cs_n), .cmd(cmd), .clk_chg_ok(clk_chg_ok),
        .reinit_req(reinit_req), .mrw_flag(mrw_flag), .busy(busy)
    );

    // Observed bits: 7 cke, 6 cs_n, 5:4 cmd, 3 chg_ok, 2 reinit, 1 mrw, 0 busy
    wire [7:0] obs = {cke, cs_n, cmd, clk_chg_ok, reinit_req, mrw_flag, busy};
    localparam logic [7:0] M_ALL  = 8'hFF;
    localparam logic [7:0] M_NOMRW = 8'hFD;

    typedef struct {
        string      tag;
        logic [7:0] mask;
        logic [7:0] exp;
    } item_t;
    item_t sbq[$];

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    function automatic logic [7:0] pk(input logic k, input logic c, input logic [1:0] m,
                                      input logic ok, input logic ri, input logic mw,
                                      input logic b);
        return {k, c, m, ok, ri, mw, b};
    endfunction

    // Driver side: queue an expected output pattern for this sample point.
    task automatic expect_o(input string tag, input logic [7:0] mask, input logic [7:0] exp);
        item_t it;
        it.tag = tag; it.mask = mask; it.exp = exp;
        sbq.push_back(it);
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: compares queued expectations against the outputs.
    always begin
        @(negedge clk);
        #1;
        while (sbq.size() > 0) begin
            item_t it;
            it = sbq.pop_front();
            total++;
            if ((obs & it.mask) !== (it.exp & it.mask)) begin
                bad++;
                $display("FAIL %s: actual=%b expected=%b mask=%b", it.tag, obs, it.exp, it.mask);
            end
        end
    end

    task automatic cfg_write(input logic [1:0] s, input logic [TW-1:0] v);
        cfg_we = 1'b1; cfg_sel = s; cfg_wdata = v;
        tick(1);
        cfg_we = 1'b0;
    endtask

    // From the cycle just after CKE dropped: open window, close it, return.
    task automatic finish_change(input string tag);
        tick(2);
        expect_o({tag, " window open"}, 8'h88, pk(0,0,2'b00,1,0,0,0));
        req_clk_done = 1'b1;
        tick(1);
        req_clk_done = 1'b0;
        tick(2);
        expect_o({tag, " back to idle with flag"}, M_ALL, pk(1,1,2'b00,0,0,1,0));
        mrw_ack = 1'b1;
        tick(1);
        mrw_ack = 1'b0;
        expect_o({tag, " flag cleared"}, M_ALL, pk(1,1,2'b00,0,0,0,0));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog (all R): actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 0; req_dpd_enter = 0; req_dpd_exit = 0; req_clk_chg = 0; req_clk_done = 0;
        bank_busy = 0; ref_ok = 1; act_issued = 0; pre_issued = 0; clk_stable = 1;
        init_done = 0; mrw_ack = 0; cfg_we = 0; cfg_sel = 0; cfg_wdata = 0;
        tick(3);
        rst_n = 1;
        expect_o("R1 reset state", M_ALL, pk(1,1,2'b00,0,0,0,0));

        // R11: program counts
        cfg_write(2'd0, 8'd3);
        cfg_write(2'd1, 8'd4);
        cfg_write(2'd2, 8'd6);
        cfg_write(2'd3, 8'd3);

        // R9: wake request while idle has no effect
        req_dpd_exit = 1; tick(1); req_dpd_exit = 0;
        tick(3);
        expect_o("R9 stray wake ignored", M_ALL, pk(1,1,2'b00,0,0,0,0));

        // R2: refresh not ready holds the clock change
        ref_ok = 0; pre_issued = 1; req_clk_chg = 1;
        tick(1);
        pre_issued = 0; req_clk_chg = 0;
        tick(7);
        expect_o("R2 held while ref_ok low", M_ALL, pk(1,1,2'b00,0,0,0,0));
        ref_ok = 1;
        tick(1);
        expect_o("R2 R12 cke drops when ready", M_NOMRW, pk(0,1,2'b00,0,0,0,1));
        tick(1);
        expect_o("R3 window closed after one low cycle", 8'h88, pk(0,0,2'b00,0,0,0,0));
        tick(1);
        expect_o("R3 window opens after two low cycles", M_NOMRW, pk(0,1,2'b00,1,0,0,1));
        tick(3);
        expect_o("R3 window stays open", 8'h88, pk(0,0,2'b00,1,0,0,0));
        clk_stable = 0; req_clk_done = 1;
        tick(1);
        req_clk_done = 0;
        expect_o("R4 window closes on done", M_NOMRW, pk(0,1,2'b00,0,0,0,1));
        tick(3);
        expect_o("R4 cke held while clock unstable", 8'h89, pk(0,0,2'b00,0,0,0,1));
        clk_stable = 1;
        tick(1);
        expect_o("R4 one stable cycle not enough", 8'h80, pk(0,0,2'b00,0,0,0,0));
        tick(1);
        expect_o("R4 R5 cke high and flag set", M_ALL, pk(1,1,2'b00,0,0,1,0));
        tick(2);
        expect_o("R5 flag persists", 8'h02, pk(0,0,2'b00,0,0,1,0));
        mrw_ack = 1; tick(1); mrw_ack = 0;
        expect_o("R5 flag cleared by ack", M_ALL, pk(1,1,2'b00,0,0,0,0));

        // R11: row-to-column timer count of 3
        act_issued = 1; req_clk_chg = 1;
        tick(1);
        act_issued = 0; req_clk_chg = 0;
        tick(3);
        expect_o("R2 R11 waits for row-to-column timer", M_ALL, pk(1,1,2'b00,0,0,0,0));
        tick(1);
        expect_o("R11 row-to-column expiry", 8'h81, pk(0,0,2'b00,0,0,0,1));
        finish_change("R5 rcd path");

        // R11: precharge timer count of 4
        pre_issued = 1; req_clk_chg = 1;
        tick(1);
        pre_issued = 0; req_clk_chg = 0;
        tick(4);
        expect_o("R11 waits for precharge timer", M_ALL, pk(1,1,2'b00,0,0,0,0));
        tick(1);
        expect_o("R11 precharge expiry", 8'h81, pk(0,0,2'b00,0,0,0,1));
        finish_change("R4 rp path");

        // R6 R10: deep power-down with competing clock change
        bank_busy = 1; req_dpd_enter = 1; req_clk_chg = 1;
        tick(1);
        req_dpd_enter = 0; req_clk_chg = 0;
        tick(2);
        expect_o("R6 held while bank busy", M_ALL, pk(1,1,2'b00,0,0,0,0));
        bank_busy = 0;
        tick(1);
        expect_o("R6 R10 entry command first", M_ALL, pk(0,0,2'b10,0,0,0,1));
        req_dpd_exit = 1;
        tick(1);
        req_dpd_exit = 0;
        expect_o("R7 no-op after entry", M_ALL, pk(0,1,2'b00,0,0,0,1));
        tick(5);
        expect_o("R8 still asleep at minimum time", M_ALL, pk(0,1,2'b00,0,0,0,1));
        clk_stable = 0;
        tick(1);
        expect_o("R9 no wake without stable clock", M_ALL, pk(0,1,2'b00,0,0,0,1));
        clk_stable = 1;
        tick(1);
        expect_o("R9 cke rises on wake", M_ALL, pk(1,1,2'b00,0,0,0,1));
        tick(3);
        expect_o("R9 setup count not done", 8'h85, pk(1,0,2'b00,0,0,0,1));
        tick(1);
        expect_o("R9 reinit requested", M_ALL, pk(1,1,2'b00,0,1,0,1));
        tick(2);
        expect_o("R9 reinit held", 8'h85, pk(1,0,2'b00,0,1,0,1));
        init_done = 1;
        tick(1);
        init_done = 0;
        expect_o("R9 R12 idle after init", M_ALL, pk(1,1,2'b00,0,0,0,0));
        tick(1);
        expect_o("R10 pending clock change served", 8'h81, pk(0,0,2'b00,0,0,0,1));
        finish_change("R10 deferred change");

        tick(2);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule